// File: doc/BRIEF.md
# Countdown event timer with register port

A single-channel countdown timer reached through a plain 32-bit register read/write port. Software places a reload value in two words, then writes a control word that starts the count, selects between a repeating and a single-event mode, and chooses a 32-bit or a 64-bit counter. Each expiry sets a sticky status flag that drives a level interrupt when the interrupt is enabled. Software acknowledges the flag by writing a one to a self-clearing clear bit.

The counter sits in one of three states. In IDLE it is stopped and frozen. In RUN it decrements once per clock. DONE is the held state after a single-event expiry. The transitions are: START (IDLE to RUN when enable goes from 0 to 1, or IDLE to DONE if the loaded value is zero); STOP (RUN or DONE to IDLE when enable is written 0); FIRE_LOOP (RUN to RUN, reloading, on expiry in repeating mode); FIRE_ONCE (RUN to DONE on expiry in single-event mode). Reading the live value low word also captures the whole counter into a shadow pair, so the two halves of a 64-bit count can be read without tearing.

Byte offsets: 0x00 reload low, 0x04 reload high, 0x08 live value low, 0x0C live value high, 0x10 control, 0x14 interrupt, 0x18 shadow low, 0x1C shadow high. Reads return their data one clock after the read strobe.

Top module: `evtimer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: The control write that moves enable (control bit 1) from 0 to 1 copies the reload value into the counter on that clock edge. From then on the counter falls by one per clock.
- R3: In single-event mode (control bit 0 clear), a reload value L raises the expiry on the L-th edge after the enabling write, for every L of 1 or more. The counter then holds at 0 with no further expiry until it is disabled and enabled again.
- R4: In repeating mode (control bit 0 set), the counter reloads L on the same edge as each expiry. The live value then cycles L, L-1, ..., 1 and an expiry occurs every L clocks.
- R5: Interrupt register layout: bit 0 enable, bit 1 raw status, bit 2 masked status, bit 3 clear. Raw status sets on every expiry even when the enable is 0. Masked status is raw AND enable, and `irq` follows masked status.
- R6: Writing 1 to bit 3 clears raw status, and bit 3 always reads 0. When an expiry and a clear fall on the same edge, raw status stays set.
- R7: With control bit 16 clear (32-bit width), only the low reload word is used, the live value high word reads 0, and reload values up to 0xFFFFFFFF count correctly.
- R8: With control bit 16 set (64-bit width), the full 64-bit reload value counts down, with borrow from the high word.
- R9: A read of the live value low word latches the counter into the shadow low and high words. These keep that snapshot while the counter moves on.
- R10: The control write that clears enable stops the counter on that edge and leaves it frozen. The reload words are unchanged.
- R11: The control word reads back with bits 0, 1 and 16 in the positions written, and the reload words read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one clock per write |
| rd_en | input | 1 | Read strobe, one clock per read |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the clock after `rd_en` |
| irq | output | 1 | Level interrupt (masked status) |

## Verification
The write that sets enable loads the counter on its own edge, so a read issued in the next cycle returns L. A read issued k cycles after that returns L-k in single-event mode, or L-(k mod L) in repeating mode. Raw status and `irq` change on the expiry edge itself, which is the L-th edge after the enabling write. Every bus task in the bench drives on a falling edge and spends exactly one cycle, so the bench tracks the exact cycle count and samples read data and `irq` on the falling edge after the edge that produced them. Sweeps over small reload values in both modes compare each cycle's value against this arithmetic. Separate directed sequences place a clear on an expiry edge, cross the 32-bit borrow, and check the shadow snapshot.

// File: rtl/evt_pkg.sv
package evt_pkg;

    // Byte offsets on the register port (software-visible)
    localparam int OFF_LOAD_LO = 'h00;
    localparam int OFF_LOAD_HI = 'h04;
    localparam int OFF_VAL_LO  = 'h08;
    localparam int OFF_VAL_HI  = 'h0C;
    localparam int OFF_CTRL    = 'h10;
    localparam int OFF_INT     = 'h14;
    localparam int OFF_SHD_LO  = 'h18;
    localparam int OFF_SHD_HI  = 'h1C;

    // Control word bit positions
    localparam int CB_REPEAT = 0;
    localparam int CB_RUN    = 1;
    localparam int CB_WIDE   = 16;

    // Interrupt word bit positions
    localparam int IB_EN    = 0;
    localparam int IB_RAW   = 1;
    localparam int IB_MASK  = 2;
    localparam int IB_CLR   = 3;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } cnt_state_e;

endpackage

// File: rtl/evt_count.sv
module evt_count
    import evt_pkg::*;
#(
    parameter int HALF_W = 32,
    parameter int CNT_W  = 2 * HALF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             start_wide_i,
    input  logic             stop_i,
    input  logic             periodic_i,
    input  logic [CNT_W-1:0] load_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             fire_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             wide_q, wide_d;
    logic             fire;

    function automatic logic [CNT_W-1:0] fit(input logic [CNT_W-1:0] v, input logic w);
        fit = w ? v : {{(CNT_W-HALF_W){1'b0}}, v[HALF_W-1:0]};
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            wide_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            wide_q  <= wide_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        wide_d  = wide_q;
        fire    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin                       // START
                    wide_d  = start_wide_i;
                    cnt_d   = fit(load_i, start_wide_i);
                    state_d = (fit(load_i, start_wide_i) == '0) ? S_DONE : S_RUN;
                end
            end
            S_RUN: begin
                if (stop_i) begin                        // STOP
                    state_d = S_IDLE;
                end else if (cnt_q == ONE) begin
                    fire = 1'b1;
                    if (periodic_i && fit(load_i, wide_q) != '0) begin
                        cnt_d = fit(load_i, wide_q);     // FIRE_LOOP
                    end else begin
                        cnt_d   = '0;                    // FIRE_ONCE
                        state_d = S_DONE;
                    end
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            S_DONE: begin
                if (stop_i) state_d = S_IDLE;            // STOP
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign cnt_o  = cnt_q;
    assign fire_o = fire;

    a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && !stop_i && cnt_q != ONE) |=> (cnt_q == $past(cnt_q) - ONE));

    a_r3_done_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE) |-> (cnt_q == '0));

    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && !stop_i && cnt_q == ONE && periodic_i && load_i[HALF_W-1:0] != '0)
        |=> (cnt_q[HALF_W-1:0] == $past(load_i[HALF_W-1:0])));

    a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !start_i) |=> $stable(cnt_q));

endmodule

// File: rtl/evt_flag.sv
module evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic en_wr_i,
    input  logic en_val_i,
    input  logic clr_i,
    output logic en_o,
    output logic raw_o,
    output logic masked_o,
    output logic irq_o
);

    logic en_q, raw_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            raw_q <= 1'b0;
        end else begin
            if (en_wr_i) en_q <= en_val_i;
            if (fire_i)      raw_q <= 1'b1;   // expiry wins over clear
            else if (clr_i)  raw_q <= 1'b0;
        end
    end

    assign en_o     = en_q;
    assign raw_o    = raw_q;
    assign masked_o = raw_q & en_q;
    assign irq_o    = masked_o;

    a_r5_raw_sets: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> raw_q);

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !fire_i) |=> !raw_q);

    a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !irq_o);

endmodule

// File: rtl/evt_rdport.sv
module evt_rdport
    import evt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5,
    parameter int CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  load_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              wide_i,
    input  logic [DATA_W-1:0] ctrl_word_i,
    input  logic [DATA_W-1:0] int_word_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] shd_lo_q, shd_hi_q, rdata_q, mux;
    logic [DATA_W-1:0] live_hi;

    assign live_hi = wide_i ? cnt_i[CNT_W-1:DATA_W] : '0;

    always_comb begin
        mux = '0;
        if      (addr_i == ADDR_W'(OFF_LOAD_LO)) mux = load_i[DATA_W-1:0];
        else if (addr_i == ADDR_W'(OFF_LOAD_HI)) mux = load_i[CNT_W-1:DATA_W];
        else if (addr_i == ADDR_W'(OFF_VAL_LO))  mux = cnt_i[DATA_W-1:0];
        else if (addr_i == ADDR_W'(OFF_VAL_HI))  mux = live_hi;
        else if (addr_i == ADDR_W'(OFF_CTRL))    mux = ctrl_word_i;
        else if (addr_i == ADDR_W'(OFF_INT))     mux = int_word_i;
        else if (addr_i == ADDR_W'(OFF_SHD_LO))  mux = shd_lo_q;
        else if (addr_i == ADDR_W'(OFF_SHD_HI))  mux = shd_hi_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            shd_lo_q <= '0;
            shd_hi_q <= '0;
        end else if (rd_i) begin
            rdata_q <= mux;
            if (addr_i == ADDR_W'(OFF_VAL_LO)) begin
                shd_lo_q <= cnt_i[DATA_W-1:0];
                shd_hi_q <= live_hi;
            end
        end
    end

    assign rdata_o = rdata_q;

    a_r7_hi_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == ADDR_W'(OFF_VAL_HI) && !wide_i) |=> (rdata_o == '0));

    a_r9_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == ADDR_W'(OFF_VAL_LO)) |=> (shd_lo_q == $past(cnt_i[DATA_W-1:0])));

endmodule

// File: rtl/evtimer.sv
module evtimer
    import evt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam int CNT_W = 2 * DATA_W;

    logic [DATA_W-1:0] load_lo_q, load_hi_q;
    logic              c_rep_q, c_run_q, c_wide_q;
    logic              wr_ctrl, wr_int, start, stop;
    logic [CNT_W-1:0]  cnt;
    logic              fire, f_en, f_raw, f_mask;
    logic [DATA_W-1:0] ctrl_word, int_word;

    assign wr_ctrl = wr_en && addr == ADDR_W'(OFF_CTRL);
    assign wr_int  = wr_en && addr == ADDR_W'(OFF_INT);
    assign start   = wr_ctrl &&  wdata[CB_RUN] && !c_run_q;
    assign stop    = wr_ctrl && !wdata[CB_RUN] &&  c_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_lo_q <= '0;
            load_hi_q <= '0;
            c_rep_q   <= 1'b0;
            c_run_q   <= 1'b0;
            c_wide_q  <= 1'b0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(OFF_LOAD_LO)) load_lo_q <= wdata;
            if (addr == ADDR_W'(OFF_LOAD_HI)) load_hi_q <= wdata;
            if (wr_ctrl) begin
                c_rep_q  <= wdata[CB_REPEAT];
                c_run_q  <= wdata[CB_RUN];
                c_wide_q <= wdata[CB_WIDE];
            end
        end
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CB_REPEAT] = c_rep_q;
        ctrl_word[CB_RUN]    = c_run_q;
        ctrl_word[CB_WIDE]   = c_wide_q;
        int_word = '0;
        int_word[IB_EN]   = f_en;
        int_word[IB_RAW]  = f_raw;
        int_word[IB_MASK] = f_mask;
    end

    evt_count #(.HALF_W(DATA_W), .CNT_W(CNT_W)) u_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .start_wide_i (wdata[CB_WIDE]),
        .stop_i       (stop),
        .periodic_i   (c_rep_q),
        .load_i       ({load_hi_q, load_lo_q}),
        .cnt_o        (cnt),
        .fire_o       (fire)
    );

    evt_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire),
        .en_wr_i  (wr_int),
        .en_val_i (wdata[IB_EN]),
        .clr_i    (wr_int && wdata[IB_CLR]),
        .en_o     (f_en),
        .raw_o    (f_raw),
        .masked_o (f_mask),
        .irq_o    (irq)
    );

    evt_rdport #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_i        (rd_en),
        .addr_i      (addr),
        .load_i      ({load_hi_q, load_lo_q}),
        .cnt_i       (cnt),
        .wide_i      (c_wide_q),
        .ctrl_word_i (ctrl_word),
        .int_word_i  (int_word),
        .rdata_o     (rdata)
    );

    a_r11_run_tracks_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (c_run_q == $past(wdata[CB_RUN])));

endmodule

// File: tb/evtimer_test.sv
`timescale 1ns/1ps
module evtimer_test;

    localparam logic [4:0] A_LLO = 5'h00, A_LHI = 5'h04, A_VLO = 5'h08, A_VHI = 5'h0C;
    localparam logic [4:0] A_CTL = 5'h10, A_INT = 5'h14, A_SLO = 5'h18, A_SHI = 5'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    evtimer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual %0d expected done", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // every bus task starts on a falling edge and spends exactly one cycle
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic prog(input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] ctl);
        wr(A_CTL, 32'h0);
        wr(A_LLO, lo);
        wr(A_LHI, hi);
        wr(A_CTL, ctl);
    endtask

    logic [31:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        for (int a = 0; a < 8; a++) begin
            rd(5'(a * 4), v);
            chk("R1 reg", v, 32'h0);
        end

        wr(A_INT, 32'h1);

        // R2/R3 single-event sweep
        for (int L = 1; L <= 6; L++) begin
            prog(32'(L), 32'h0, 32'h2);
            for (int k = 0; k <= L + 2; k++) begin
                rd(A_VLO, v);
                chk("R3 value", v, (k < L) ? 32'(L - k) : 32'h0);
                chk("R5 irq", {31'b0, irq}, (k + 1 >= L) ? 32'h1 : 32'h0);
            end
            wr(A_INT, 32'h9);
            chk("R6 cleared", {31'b0, irq}, 32'h0);
            idle(4);
            chk("R3 no second event", {31'b0, irq}, 32'h0);
        end

        // R4 repeating sweep
        for (int L = 1; L <= 4; L++) begin
            prog(32'(L), 32'h0, 32'h3);
            for (int k = 0; k < 3 * L; k++) begin
                rd(A_VLO, v);
                chk("R4 value", v, 32'(L - (k % L)));
            end
            chk("R4 irq", {31'b0, irq}, 32'h1);
            wr(A_INT, 32'h9);
            idle(L);
            chk("R4 event repeats", {31'b0, irq}, 32'h1);
            wr(A_CTL, 32'h0);
            wr(A_INT, 32'h9);
        end

        // R5 masking
        wr(A_INT, 32'h0);
        prog(32'd2, 32'h0, 32'h2);
        idle(3);
        rd(A_INT, v);
        chk("R5 raw only", v, 32'h2);
        chk("R5 irq masked", {31'b0, irq}, 32'h0);
        wr(A_INT, 32'h1);
        chk("R5 irq unmasked", {31'b0, irq}, 32'h1);
        rd(A_INT, v);
        chk("R5 int word", v, 32'h7);
        wr(A_INT, 32'h9);
        rd(A_INT, v);
        chk("R6 clear reads 0", v, 32'h1);

        // R6 expiry on the clear edge wins
        prog(32'd2, 32'h0, 32'h3);
        idle(1);
        wr(A_INT, 32'h9);
        rd(A_INT, v);
        chk("R6 expiry wins", v, 32'h7);
        wr(A_CTL, 32'h0);
        wr(A_INT, 32'h9);
        chk("R6 cleared after", {31'b0, irq}, 32'h0);

        // R8/R9 64-bit borrow and shadow
        prog(32'd2, 32'd1, 32'h10002);
        rd(A_VLO, v); chk("R8 lo start", v, 32'd2);
        rd(A_SHI, v); chk("R9 shadow hi", v, 32'd1);
        rd(A_SLO, v); chk("R9 shadow lo", v, 32'd2);
        rd(A_VHI, v); chk("R8 hi after borrow", v, 32'd0);
        rd(A_VLO, v); chk("R8 lo after borrow", v, 32'hFFFFFFFE);
        rd(A_CTL, v); chk("R11 ctrl", v, 32'h10002);
        rd(A_LHI, v); chk("R11 load hi", v, 32'd1);
        chk("R8 no expiry", {31'b0, irq}, 32'h0);

        // R7 32-bit ignores high word
        prog(32'd5, 32'd7, 32'h2);
        rd(A_VHI, v); chk("R7 hi zero", v, 32'd0);
        rd(A_VLO, v); chk("R7 lo", v, 32'd4);
        rd(A_SHI, v); chk("R7 shadow hi zero", v, 32'd0);
        idle(1);
        chk("R7 before expiry", {31'b0, irq}, 32'h0);
        idle(1);
        chk("R7 expiry at 5", {31'b0, irq}, 32'h1);
        wr(A_INT, 32'h9);

        // R7 largest 32-bit value
        prog(32'hFFFFFFFF, 32'h0, 32'h2);
        rd(A_VLO, v); chk("R7 max", v, 32'hFFFFFFFF);
        rd(A_VLO, v); chk("R7 max-1", v, 32'hFFFFFFFE);

        // R10 freeze and R2 restart
        prog(32'd10, 32'h0, 32'h2);
        wr(A_CTL, 32'h0);
        rd(A_VLO, v); chk("R10 frozen", v, 32'd10);
        idle(3);
        rd(A_VLO, v); chk("R10 still frozen", v, 32'd10);
        rd(A_LLO, v); chk("R10 load kept", v, 32'd10);
        chk("R10 no irq", {31'b0, irq}, 32'h0);
        wr(A_CTL, 32'h2);
        rd(A_VLO, v); chk("R2 reload on enable", v, 32'd10);
        rd(A_VLO, v); chk("R2 decrement", v, 32'd9);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule